// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block runs one multiply-accumulate operation for each valid strobe. An 11-bit operation word selects the variant. The low six bits select the accumulator layout. The split layout keeps a 64-bit accumulator whose upper half sits in the low word of HI and whose lower half sits in the low word of LO. The double layout accumulates into the whole of LO and leaves HI alone.

The five bits above the layout code carry three flags:
- whether the multiply is signed or unsigned,
- whether the sum saturates or wraps,
- whether the HI or the LO half is returned as the result.

Only the low 32 bits of each 64-bit register operand enter the multiplier. The updated HI, LO and the register result are registered. They appear one clock after the strobe is sampled. An operation word outside the accepted set raises the illegal flag and changes no other state. The block is meant to sit beside an integer pipeline as its multiply-accumulate execution stage.

Top module: `mac_sat_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hi`, `lo` and `result` become zero and `illegal` becomes 0.
- R2: An operation is accepted only in these cases:
  - Split layout: `instr[5:0]` = 6'b101000 and `instr[8:7]` = 0.
  - Double layout: `instr[5:0]` = 6'b101001 and `instr[9:7]` = 0.

  Any other word sampled with `valid` sets `illegal` to 1 and leaves `hi`, `lo` and `result` unchanged. An accepted operation clears `illegal`.
- R3: A wrapping split operation (`instr[10]` = 0) adds the product to the 64-bit value {`hi[31:0]`,`lo[31:0]`} modulo 2^64. It then stores each 32-bit half of the sum, sign-extended to 64 bits, in `hi` and `lo`.
- R4: In the split layout, `instr[9]` = 1 returns the new `hi` as `result`, and `instr[9]` = 0 returns the new `lo`. Both are sign-extended.
- R5: The double layout adds the product to the whole 64-bit `lo`. It stores the sum in `lo`, returns it unchanged as `result`, and leaves `hi` unchanged.
- R6: With `instr[10]` = 1 and `instr[6]` = 0, the exact signed sum is clamped:
  - A sum above 0x7FFFFFFF becomes 0x7FFFFFFF.
  - A sum below -2^31 becomes 0xFFFFFFFF80000000.
- R7: With `instr[10]` = 1 and `instr[6]` = 1, an exact unsigned sum above 0x7FFFFFFF becomes all ones.
- R8: `instr[6]` = 1 multiplies the operands' low 32 bits as unsigned numbers, and 0 multiplies them as two's-complement numbers. Bits 63:32 of both operands have no effect.
- R9: A cycle with `valid` low changes none of `hi`, `lo`, `result` and `illegal`.
- R10: `hi[63:32]` always equals 32 copies of `hi[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Operation strobe |
| instr | input | 11 | Operation word: layout code in [5:0], flags in [10:6] |
| rs_val | input | 64 | First register operand (low 32 bits used) |
| rt_val | input | 64 | Second register operand (low 32 bits used) |
| result | output | 64 | Register result of the last accepted operation |
| hi | output | 64 | HI accumulator state |
| lo | output | 64 | LO accumulator state |
| illegal | output | 1 | Last sampled operation word was not accepted |

## Verification
Saturation and accumulator overflow can occur in the same operation. A sum can exceed 64 bits, and it can also pass a 32-bit limit. The clamp must act on the exact sum, not on the wrapped one. The bench provokes this by first driving the accumulator close to 2^64 with unsigned wrapping operations, then issuing signed and unsigned saturating operations. A 128-bit bench model computes the exact sum and judges the clamped value.

// File: rtl/mac_sat_pkg.sv
// Package: shared decode types and layout codes for the multiply-accumulate unit.
// Assumes the layout code occupies bits 5:0 of the operation word.
package mac_sat_pkg;

    localparam logic [5:0] FN_SPLIT  = 6'b101000;
    localparam logic [5:0] FN_DOUBLE = 6'b101001;

    typedef struct packed {
        logic legal;    // word is in the accepted set
        logic dbl;      // double layout: LO only
        logic sat;      // saturate instead of wrapping
        logic take_hi;  // return HI half (split layout)
        logic uns;      // unsigned multiply and sum
    } mac_op_t;

endpackage

// File: rtl/mac_sat_decode.sv
// Module: mac_sat_decode
// Turns the 11-bit operation word into control flags.
// Assumes IW >= 11; bits above 10 must be zero for a word to be accepted.
module mac_sat_decode
    import mac_sat_pkg::*;
#(
    parameter int IW = 11
) (
    input  logic [IW-1:0] instr,
    output mac_op_t       op
);

    logic [5:0] fn;
    logic [4:0] fld;

    // Split the word into its layout code and flag field.
    always_comb begin
        fn  = instr[5:0];
        fld = instr[10:6];
    end

    // Derive the flags and the acceptance test.
    always_comb begin
        op.sat     = fld[4];
        op.take_hi = fld[3];
        op.uns     = fld[0];
        op.dbl     = (fn == FN_DOUBLE);
        op.legal   = ((fn == FN_SPLIT)  && (fld[2:1] == 2'b00)) ||
                     ((fn == FN_DOUBLE) && (fld[3:1] == 3'b000));
        if (IW > 11) begin
            if (instr >> 11 != '0) op.legal = 1'b0;
        end
    end

endmodule

// File: rtl/mac_sat_mul.sv
// Module: mac_sat_mul
// One HALF x HALF multiplier shared by the signed and unsigned forms.
// Both operands are extended to W bits by sign or zero, and the low W bits
// of the product are kept. This is exact for either form.
module mac_sat_mul #(
    parameter int W    = 64,
    parameter int HALF = W / 2
) (
    input  logic [HALF-1:0] a,
    input  logic [HALF-1:0] b,
    input  logic            uns,
    output logic [W-1:0]    prod
);

    logic [W-1:0] ax;
    logic [W-1:0] bx;

    // Extend both operands according to the signedness flag, then multiply.
    always_comb begin
        ax   = {{(W-HALF){a[HALF-1] & ~uns}}, a};
        bx   = {{(W-HALF){b[HALF-1] & ~uns}}, b};
        prod = ax * bx;
    end

endmodule

// File: rtl/mac_sat_adder.sv
// Module: mac_sat_adder
// Adds the product to the accumulator with two guard bits, so the sum is
// exact, then wraps or saturates.
// Assumes the accumulator and product are read unsigned when uns is set
// and signed otherwise.
module mac_sat_adder #(
    parameter int W    = 64,
    parameter int HALF = W / 2
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] prod,
    input  logic         sat,
    input  logic         uns,
    output logic [W-1:0] sum
);

    localparam int XW = W + 2;
    localparam logic [XW-1:0] POS_LIM = {{(XW-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
    localparam logic [XW-1:0] NEG_LIM = {{(XW-HALF+1){1'b1}}, {(HALF-1){1'b0}}};

    logic [XW-1:0] acc_x;
    logic [XW-1:0] prod_x;
    logic [XW-1:0] total;

    // Exact sum with guard bits.
    always_comb begin
        acc_x  = {{2{acc[W-1] & ~uns}}, acc};
        prod_x = {{2{prod[W-1] & ~uns}}, prod};
        total  = acc_x + prod_x;
    end

    // Choose the wrapped, clamped or forced-to-ones value.
    always_comb begin
        sum = total[W-1:0];
        if (sat) begin
            if (uns) begin
                if (total > POS_LIM) sum = '1;
            end else if ($signed(total) > $signed(POS_LIM)) begin
                sum = POS_LIM[W-1:0];
            end else if ($signed(total) < $signed(NEG_LIM)) begin
                sum = NEG_LIM[W-1:0];
            end
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
// Module: mac_sat_unit (top)
// Multiply-accumulate unit with split HI:LO or LO-only accumulation,
// optional saturation and HI/LO result select.
// The state updates on the clock edge that samples valid.
// Assumes W is even.
module mac_sat_unit
    import mac_sat_pkg::*;
#(
    parameter int W  = 64,
    parameter int IW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [IW-1:0] instr,
    input  logic [W-1:0]  rs_val,
    input  logic [W-1:0]  rt_val,
    output logic [W-1:0]  result,
    output logic [W-1:0]  hi,
    output logic [W-1:0]  lo,
    output logic          illegal
);

    localparam int HALF = W / 2;

    mac_op_t      op;
    logic [W-1:0] prod;
    logic [W-1:0] acc_in;
    logic [W-1:0] sum;
    logic [W-1:0] hi_nx;
    logic [W-1:0] lo_nx;
    logic [W-1:0] res_nx;
    logic         unused_upper;

    // Operand bits above HALF never reach the multiplier.
    assign unused_upper = ^{rs_val[W-1:HALF], rt_val[W-1:HALF]};

    mac_sat_decode #(.IW(IW)) u_dec (
        .instr (instr),
        .op    (op)
    );

    mac_sat_mul #(.W(W), .HALF(HALF)) u_mul (
        .a    (rs_val[HALF-1:0]),
        .b    (rt_val[HALF-1:0]),
        .uns  (op.uns),
        .prod (prod)
    );

    // Accumulator view: whole LO for the double layout, joined halves otherwise.
    always_comb begin
        acc_in = op.dbl ? lo : {hi[HALF-1:0], lo[HALF-1:0]};
    end

    mac_sat_adder #(.W(W), .HALF(HALF)) u_add (
        .acc  (acc_in),
        .prod (prod),
        .sat  (op.sat),
        .uns  (op.uns),
        .sum  (sum)
    );

    // Form the next HI, LO and result from the sum.
    always_comb begin
        if (op.dbl) begin
            hi_nx  = hi;
            lo_nx  = sum;
            res_nx = sum;
        end else begin
            hi_nx  = {{(W-HALF){sum[W-1]}}, sum[W-1:HALF]};
            lo_nx  = {{(W-HALF){sum[HALF-1]}}, sum[HALF-1:0]};
            res_nx = op.take_hi ? hi_nx : lo_nx;
        end
    end

    // State registers: reset, accepted update, or rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi      <= '0;
            lo      <= '0;
            result  <= '0;
            illegal <= 1'b0;
        end else if (valid) begin
            illegal <= ~op.legal;
            if (op.legal) begin
                hi     <= hi_nx;
                lo     <= lo_nx;
                result <= res_nx;
            end
        end
    end

endmodule

// File: rtl/mac_sat_unit_chk.sv
// Module: mac_sat_unit_chk
// Temporal checks on the multiply-accumulate unit, attached by bind.
module mac_sat_unit_chk #(
    parameter int W  = 64,
    parameter int IW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid,
    input logic [IW-1:0] instr,
    input logic [W-1:0]  result,
    input logic [W-1:0]  hi,
    input logic [W-1:0]  lo,
    input logic          illegal
);

    localparam int HALF = W / 2;
    localparam logic [W-1:0] POS_LIM = {{(W-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {{(W-HALF+1){1'b1}}, {(HALF-1){1'b0}}};

    logic dbl_any;
    logic dbl_sat_s;
    logic dbl_sat_u;

    // Recognise the accepted double-layout words.
    always_comb begin
        dbl_any   = (instr == IW'(11'b00000_101001)) || (instr == IW'(11'b10000_101001)) ||
                    (instr == IW'(11'b00001_101001)) || (instr == IW'(11'b10001_101001));
        dbl_sat_s = (instr == IW'(11'b10000_101001));
        dbl_sat_u = (instr == IW'(11'b10001_101001));
    end

    // R2: a rejected word leaves all state untouched
    a_r2_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (illegal |-> ($stable(hi) && $stable(lo) && $stable(result))));

    // R5: double layout leaves HI and returns LO
    a_r5_double_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dbl_any) |=> ($stable(hi) && (result == lo) && !illegal));

    // R6: signed saturation keeps the double accumulator in range
    a_r6_signed_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dbl_sat_s) |=> (($signed(lo) <= $signed(POS_LIM)) && ($signed(lo) >= $signed(NEG_LIM))));

    // R7: unsigned saturation gives all ones or a value within the limit
    a_r7_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dbl_sat_u) |=> ((lo == '1) || (lo <= POS_LIM)));

    // R9: an idle cycle changes nothing
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(hi) && $stable(lo) && $stable(result) && $stable(illegal)));

    // R10: HI stays sign-extended
    a_r10_hi_sext: assert property (@(posedge clk) disable iff (!rst_n)
        hi[W-1:HALF] == {(W-HALF){hi[HALF-1]}});

endmodule

bind mac_sat_unit mac_sat_unit_chk #(.W(W), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (valid),
    .instr   (instr),
    .result  (result),
    .hi      (hi),
    .lo      (lo),
    .illegal (illegal)
);

// File: tb/mac_sat_unit_test.sv
`timescale 1ns/1ps
module mac_sat_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [10:0] instr = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic [63:0] result, hi, lo;
    logic        illegal;

    int n_run  = 0;
    int n_fail = 0;

    // model state
    logic [63:0] m_hi = '0, m_lo = '0, m_res = '0;
    logic        m_ill = 1'b0;

    mac_sat_unit uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val),
        .result(result), .hi(hi), .lo(lo), .illegal(illegal)
    );

    always #4 clk = ~clk;

    function automatic bit accepted(input logic [10:0] w);
        case (w)
            11'b00000_101000, 11'b10000_101000, 11'b00001_101000, 11'b10001_101000,
            11'b01000_101000, 11'b11000_101000, 11'b01001_101000, 11'b11001_101000,
            11'b00000_101001, 11'b10000_101001, 11'b00001_101001, 11'b10001_101001:
                return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Exact 128-bit reference of one accepted operation; updates model state.
    task automatic model_step(input logic [10:0] w, input logic [63:0] a, input logic [63:0] b);
        logic signed [127:0] ea, eb, acc, t;
        logic [63:0] s;
        bit uns, sat, dbl, sel_hi;
        if (!accepted(w)) begin
            m_ill = 1'b1;
            return;
        end
        m_ill  = 1'b0;
        uns    = w[6];
        sat    = w[10];
        sel_hi = w[9];
        dbl    = (w[5:0] == 6'b101001);
        ea = uns ? {96'b0, a[31:0]} : {{96{a[31]}}, a[31:0]};
        eb = uns ? {96'b0, b[31:0]} : {{96{b[31]}}, b[31:0]};
        s  = dbl ? m_lo : {m_hi[31:0], m_lo[31:0]};
        acc = uns ? {64'b0, s} : {{64{s[63]}}, s};
        t = acc + ea * eb;
        if (sat && uns && t > 128'sh7FFF_FFFF) t = -128'sd1;
        else if (sat && !uns && t > 128'sh7FFF_FFFF) t = 128'sh7FFF_FFFF;
        else if (sat && !uns && t < -128'sh8000_0000) t = -128'sh8000_0000;
        if (dbl) begin
            m_lo  = t[63:0];
            m_res = t[63:0];
        end else begin
            m_hi  = {{32{t[63]}}, t[63:32]};
            m_lo  = {{32{t[31]}}, t[31:0]};
            m_res = sel_hi ? m_hi : m_lo;
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "result", result, m_res);
        chk(tag, "hi", hi, m_hi);
        chk(tag, "lo", lo, m_lo);
        chk(tag, "illegal", {63'b0, illegal}, {63'b0, m_ill});
    endtask

    // Drive one operation at a falling edge; check after the next falling edge.
    task automatic op(input string tag, input logic [10:0] w, input logic [63:0] a, input logic [63:0] b);
        instr = w; rs_val = a; rt_val = b; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        model_step(w, a, b);
        chk_all(tag);
    endtask

    task automatic idle(input string tag);
        instr = 11'b00000_101000; rs_val = 64'h1234; rt_val = 64'h5678;
        @(negedge clk);
        chk_all(tag);
    endtask

    localparam logic [10:0] W_MACC    = 11'b00000_101000;
    localparam logic [10:0] W_MACCS   = 11'b10000_101000;
    localparam logic [10:0] W_MACCU   = 11'b00001_101000;
    localparam logic [10:0] W_MACCUS  = 11'b10001_101000;
    localparam logic [10:0] W_MACCHI  = 11'b01000_101000;
    localparam logic [10:0] W_HIS     = 11'b11000_101000;
    localparam logic [10:0] W_HIU     = 11'b01001_101000;
    localparam logic [10:0] W_DMACC   = 11'b00000_101001;
    localparam logic [10:0] W_DMACCS  = 11'b10000_101001;
    localparam logic [10:0] W_DMACCU  = 11'b00001_101001;
    localparam logic [10:0] W_DMACCUS = 11'b10001_101001;

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;

        // R3 R8: signed wrap with garbage upper operand bits
        op("R3_R8", W_MACC, 64'hDEAD_BEEF_FFFF_FFFD, 64'hCAFE_0000_0000_0005);
        // R4: HI half returned
        op("R4", W_MACCHI, 64'h1_0001_0000, 64'hF_0001_0000);
        op("R4", W_HIU, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        // R6: clamp high then low
        op("R6", W_MACCS, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
        op("R6", W_MACCS, 64'h8000_0000, 64'h7FFF_FFFF);
        op("R6", W_HIS, 64'h8000_0000, 64'h7FFF_FFFF);
        // R7: forced to ones, stays there
        op("R7", W_MACCUS, 64'h2, 64'h3);
        op("R7", W_MACCUS, 64'h4000_0000, 64'h2);
        op("R7", W_MACCUS, 64'h0, 64'h0);
        // R3: wrap past 2^64 from all ones
        op("R3", W_MACCU, 64'h2, 64'h3);
        // R2: rejected words hold state
        op("R2", 11'b00100_101000, 64'h5, 64'h5);
        op("R2", 11'b01000_101001, 64'h5, 64'h5);
        op("R2", 11'b00000_000000, 64'h5, 64'h5);
        op("R2", W_MACC, 64'h5, 64'h5);
        // R5: double layout, including saturation against an exact sum
        op("R5", W_DMACC, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        op("R5", W_DMACCU, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        op("R5_R6", W_DMACCS, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
        op("R5_R6", W_DMACCS, 64'h8000_0000, 64'h7FFF_FFFF);
        op("R5_R6", W_DMACCS, 64'h8000_0000, 64'h7FFF_FFFF);
        op("R5_R7", W_DMACCUS, 64'h1, 64'h1);
        // R9: idle cycles
        idle("R9");
        idle("R9");
        // R6 R7 with a near-2^64 accumulator: overflow and saturation together
        for (int k = 0; k < 4; k++) op("R3", W_MACCU, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        op("R7", W_MACCUS, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) op("R3", W_DMACCU, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        op("R6", W_DMACCS, 64'hFFFF_FFFF, 64'hFFFF_FFFF);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [10:0] w;
            logic [63:0] a, b;
            int r;
            r = int'($urandom % 16);
            case (r)
                0:       w = 11'($urandom);
                1:       w = {5'($urandom), 6'b101001};
                2:       w = {5'($urandom), 6'b101000};
                3, 4, 5: w = {$urandom % 2 == 0 ? 1'b0 : 1'b1, 3'b000, 1'($urandom), 6'b101001};
                default: w = {1'($urandom), 1'($urandom), 2'b00, 1'($urandom), 6'b101000};
            endcase
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 3 == 0) begin
                a[31:0] = $urandom % 64;
                b[31:0] = $urandom % 64;
            end
            if ($urandom % 10 == 0) idle("R9");
            else op(accepted(w) ? "R3_R4_R8" : "R2", w, a, b);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule